// File: doc/BRIEF.md
# Burst-of-Four Split-Port SRAM Core

This block is a synchronous memory with a write data port and a read data port that never share wires, so no dead cycle is ever spent turning a bus around. One address bus serves both ports. A free-running slot counter, cleared by reset, gives even cycles to read addresses and odd cycles to write addresses. Each address names a group of four words that always moves as a sequential burst.

Double-rate transfer is modelled at one clock rate. Each data bus is two words wide, so a burst takes two cycles on either port. A write burst is staged until all four words are held and is then committed to the array in one step. A read that names a staged, uncommitted write is served from the staging register for the words already received. As a result, every read returns the data of all writes whose address slot came before it.

Each port has its own active-low select. A deasserted select drops only that port's address slot, and the other port keeps running. The word width is a parameter, and the library is used at 8, 18 and 36 bits.

Top module: `qb_burst_sram`

## Requirements
- R1: After reset `rd_valid_o` is 0 and `rd_data_o` is 0. The first cycle after reset is released is slot 0, an even slot and therefore a read slot.
- R2: A select that is asserted in the other port's slot has no effect. A low `wr_sel_n_i` in an even slot writes nothing, and a low `rd_sel_n_i` in an odd slot starts no burst.
- R3: The write data bus carries word 0 in bits [WORD_W-1:0] and word 1 in the upper half in the cycle after the write address. Words 2 and 3 follow, in the same lane order, in the next cycle.
- R4: A read address accepted in cycle N raises `rd_valid_o` in cycles N+2 and N+3. Words 0 and 1 (word 0 low) appear in cycle N+2, and words 2 and 3 appear in cycle N+3.
- R5: Whenever `rd_valid_o` is 0, `rd_data_o` is all zeros. `rd_valid_o` is never high except in the two cycles after an accepted read.
- R6: With `rd_sel_n_i` high in a read slot, no burst is produced while writes continue. With `wr_sel_n_i` high in a write slot, the array is left unchanged while reads continue.
- R7: A read in the slot directly after a write address to the same location returns all four new words. The words already received come from staging.
- R8: Reads in every even slot and writes in every odd slot are sustained with no gap, and each read returns correct data.
- R9: A read whose address slot precedes a write to the same location returns the old contents. A later read returns the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Shared burst address: read address in even slots, write address in odd slots |
| rd_sel_n_i | input | 1 | Active-low read select, sampled in even slots |
| wr_sel_n_i | input | 1 | Active-low write select, sampled in odd slots |
| wr_data_i | input | 2*WORD_W | Two write words per cycle, lower word first |
| rd_data_o | output | 2*WORD_W | Two read words per cycle, lower word first |
| rd_valid_o | output | 1 | High while burst data is on `rd_data_o` |

## Verification
The bound checker keeps its own slot parity and checks on every cycle that each accepted read yields exactly two valid beats at the fixed latency. It also checks that a deselected read slot yields none, and that the read bus is zero while not valid. Data content cannot be judged cycle by cycle from the ports alone. Forwarding from staging, write ordering against reads, ignored out-of-slot selects and dropped writes are therefore shown only by the bench's scenarios, which compare every returned beat against a reference memory updated in address-slot order.

// File: rtl/qb_pkg.sv
package qb_pkg;
   localparam int unsigned BURST_WORDS = 4;
   localparam int unsigned BEAT_WORDS  = 2;

   typedef enum logic {
      SLOT_READ  = 1'b0,
      SLOT_WRITE = 1'b1
   } slot_e;
endpackage

// File: rtl/qb_slot_seq.sv
module qb_slot_seq
   import qb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd_sel_n,
   input  logic wr_sel_n,
   output logic rd_take_o,
   output logic wr_take_o,
   output logic beat_lo_o,
   output logic beat_hi_o
);
   slot_e slot_q;
   logic  lo_q, hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= SLOT_READ;
         lo_q   <= 1'b0;
         hi_q   <= 1'b0;
      end else begin
         slot_q <= (slot_q == SLOT_READ) ? SLOT_WRITE : SLOT_READ;
         lo_q   <= wr_take_o;
         hi_q   <= lo_q;
      end
   end

   assign rd_take_o = (slot_q == SLOT_READ)  && !rd_sel_n;
   assign wr_take_o = (slot_q == SLOT_WRITE) && !wr_sel_n;
   assign beat_lo_o = lo_q;
   assign beat_hi_o = hi_q;
endmodule

// File: rtl/qb_write_stage.sv
module qb_write_stage
   import qb_pkg::*;
#(
   parameter int unsigned WORD_W = 18,
   parameter int unsigned ADDR_W = 6
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [ADDR_W-1:0]                   addr_i,
   input  logic                                wr_take_i,
   input  logic                                beat_lo_i,
   input  logic                                beat_hi_i,
   input  logic [BEAT_WORDS*WORD_W-1:0]        wr_data_i,
   output logic                                st_v_o,
   output logic                                st_loh_o,
   output logic [ADDR_W-1:0]                   st_addr_o,
   output logic [BEAT_WORDS*WORD_W-1:0]        st_lo_o,
   output logic                                cm_en_o,
   output logic [ADDR_W-1:0]                   cm_addr_o,
   output logic [BURST_WORDS*WORD_W-1:0]       cm_data_o
);
   localparam int unsigned BEAT_W = BEAT_WORDS * WORD_W;

   logic              st_v_q, st_loh_q;
   logic [ADDR_W-1:0] st_addr_q;
   logic [BEAT_W-1:0] st_lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_v_q    <= 1'b0;
         st_loh_q  <= 1'b0;
         st_addr_q <= '0;
         st_lo_q   <= '0;
      end else begin
         if (wr_take_i) begin
            st_v_q    <= 1'b1;
            st_loh_q  <= 1'b0;
            st_addr_q <= addr_i;
         end else if (beat_hi_i) begin
            st_v_q   <= 1'b0;
            st_loh_q <= 1'b0;
         end else if (beat_lo_i) begin
            st_loh_q <= 1'b1;
         end
         if (beat_lo_i) st_lo_q <= wr_data_i;
      end
   end

   assign st_v_o    = st_v_q;
   assign st_loh_o  = st_loh_q;
   assign st_addr_o = st_addr_q;
   assign st_lo_o   = st_lo_q;
   assign cm_en_o   = beat_hi_i && st_v_q;
   assign cm_addr_o = st_addr_q;
   assign cm_data_o = {wr_data_i, st_lo_q};
endmodule

// File: rtl/qb_burst_array.sv
module qb_burst_array
   import qb_pkg::*;
#(
   parameter int unsigned WORD_W      = 18,
   parameter int unsigned ADDR_W      = 6,
   parameter bit          LANES_SPLIT = 1'b1
) (
   input  logic                          clk,
   input  logic                          we_i,
   input  logic [ADDR_W-1:0]             waddr_i,
   input  logic [BURST_WORDS*WORD_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0]             ra_lo_i,
   input  logic [ADDR_W-1:0]             ra_hi_i,
   output logic [BEAT_WORDS*WORD_W-1:0]  lo_pair_o,
   output logic [BEAT_WORDS*WORD_W-1:0]  hi_pair_o
);
   localparam int unsigned DEPTH  = 1 << ADDR_W;
   localparam int unsigned BEAT_W = BEAT_WORDS * WORD_W;
   localparam int unsigned LINE_W = BURST_WORDS * WORD_W;

   generate
      if (LANES_SPLIT) begin : g_split
         logic [WORD_W-1:0] lane_rd [BURST_WORDS];
         for (genvar g = 0; g < BURST_WORDS; g++) begin : g_lane
            logic [WORD_W-1:0] mem [DEPTH];
            always_ff @(posedge clk) begin
               if (we_i) mem[waddr_i] <= wdata_i[g*WORD_W +: WORD_W];
            end
            if (g < BEAT_WORDS) begin : g_lo
               assign lane_rd[g] = mem[ra_lo_i];
            end else begin : g_hi
               assign lane_rd[g] = mem[ra_hi_i];
            end
         end
         assign lo_pair_o = {lane_rd[1], lane_rd[0]};
         assign hi_pair_o = {lane_rd[3], lane_rd[2]};
      end else begin : g_wide
         logic [LINE_W-1:0] mem [DEPTH];
         logic [LINE_W-1:0] line_lo, line_hi;
         always_ff @(posedge clk) begin
            if (we_i) mem[waddr_i] <= wdata_i;
         end
         assign line_lo   = mem[ra_lo_i];
         assign line_hi   = mem[ra_hi_i];
         assign lo_pair_o = line_lo[BEAT_W-1:0];
         assign hi_pair_o = line_hi[LINE_W-1:BEAT_W];
      end
   endgenerate
endmodule

// File: rtl/qb_read_pipe.sv
module qb_read_pipe
   import qb_pkg::*;
#(
   parameter int unsigned WORD_W    = 18,
   parameter int unsigned ADDR_W    = 6,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_take_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [BEAT_WORDS*WORD_W-1:0] lo_pair_i,
   input  logic [BEAT_WORDS*WORD_W-1:0] hi_pair_i,
   input  logic                         st_v_i,
   input  logic                         st_loh_i,
   input  logic [ADDR_W-1:0]            st_addr_i,
   input  logic [BEAT_WORDS*WORD_W-1:0] st_lo_i,
   output logic [ADDR_W-1:0]            p1_addr_o,
   output logic [ADDR_W-1:0]            p2_addr_o,
   output logic [BEAT_WORDS*WORD_W-1:0] rd_data_o,
   output logic                         rd_valid_o
);
   localparam int unsigned BEAT_W = BEAT_WORDS * WORD_W;

   logic              p1_v, p2_v, vld_q;
   logic [ADDR_W-1:0] p1_a, p2_a;
   logic [BEAT_W-1:0] data_q, nxt_data;
   logic              fwd, beat_any;

   assign fwd      = st_v_i && st_loh_i && (st_addr_i == p1_a);
   assign nxt_data = p1_v ? (fwd ? st_lo_i : lo_pair_i) : hi_pair_i;
   assign beat_any = p1_v || p2_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p1_v  <= 1'b0;
         p2_v  <= 1'b0;
         p1_a  <= '0;
         p2_a  <= '0;
         vld_q <= 1'b0;
      end else begin
         p1_v  <= rd_take_i;
         p1_a  <= addr_i;
         p2_v  <= p1_v;
         p2_a  <= p1_a;
         vld_q <= beat_any;
      end
   end

   generate
      if (ZERO_IDLE) begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  data_q <= '0;
            else         data_q <= beat_any ? nxt_data : '0;
         end
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        data_q <= '0;
            else if (beat_any) data_q <= nxt_data;
         end
      end
   endgenerate

   assign p1_addr_o  = p1_a;
   assign p2_addr_o  = p2_a;
   assign rd_data_o  = data_q;
   assign rd_valid_o = vld_q;
endmodule

// File: rtl/qb_burst_sram.sv
module qb_burst_sram
   import qb_pkg::*;
#(
   parameter int unsigned WORD_W      = 18,
   parameter int unsigned ADDR_W      = 6,
   parameter bit          LANES_SPLIT = 1'b1,
   parameter bit          ZERO_IDLE   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic                         rd_sel_n_i,
   input  logic                         wr_sel_n_i,
   input  logic [2*WORD_W-1:0]          wr_data_i,
   output logic [2*WORD_W-1:0]          rd_data_o,
   output logic                         rd_valid_o
);
   localparam int unsigned BEAT_W = BEAT_WORDS * WORD_W;
   localparam int unsigned LINE_W = BURST_WORDS * WORD_W;

   generate
      if (WORD_W < 1 || WORD_W > 72) begin : g_bad_width
         $error("qb_burst_sram: WORD_W out of range");
      end
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("qb_burst_sram: ADDR_W out of range");
      end
   endgenerate

   logic              rd_take, wr_take, beat_lo, beat_hi;
   logic              st_v, st_loh, cm_en;
   logic [ADDR_W-1:0] st_addr, cm_addr, p1_addr, p2_addr;
   logic [BEAT_W-1:0] st_lo, lo_pair, hi_pair;
   logic [LINE_W-1:0] cm_data;

   qb_slot_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_sel_n  (rd_sel_n_i),
      .wr_sel_n  (wr_sel_n_i),
      .rd_take_o (rd_take),
      .wr_take_o (wr_take),
      .beat_lo_o (beat_lo),
      .beat_hi_o (beat_hi)
   );

   qb_write_stage #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr_i),
      .wr_take_i (wr_take),
      .beat_lo_i (beat_lo),
      .beat_hi_i (beat_hi),
      .wr_data_i (wr_data_i),
      .st_v_o    (st_v),
      .st_loh_o  (st_loh),
      .st_addr_o (st_addr),
      .st_lo_o   (st_lo),
      .cm_en_o   (cm_en),
      .cm_addr_o (cm_addr),
      .cm_data_o (cm_data)
   );

   qb_burst_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LANES_SPLIT(LANES_SPLIT)) u_array (
      .clk       (clk),
      .we_i      (cm_en),
      .waddr_i   (cm_addr),
      .wdata_i   (cm_data),
      .ra_lo_i   (p1_addr),
      .ra_hi_i   (p2_addr),
      .lo_pair_o (lo_pair),
      .hi_pair_o (hi_pair)
   );

   qb_read_pipe #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .ZERO_IDLE(ZERO_IDLE)) u_rpipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_take_i  (rd_take),
      .addr_i     (addr_i),
      .lo_pair_i  (lo_pair),
      .hi_pair_i  (hi_pair),
      .st_v_i     (st_v),
      .st_loh_i   (st_loh),
      .st_addr_i  (st_addr),
      .st_lo_i    (st_lo),
      .p1_addr_o  (p1_addr),
      .p2_addr_o  (p2_addr),
      .rd_data_o  (rd_data_o),
      .rd_valid_o (rd_valid_o)
   );
endmodule

// File: rtl/qb_sram_chk.sv
module qb_sram_chk #(
   parameter int unsigned WORD_W    = 18,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_sel_n_i,
   input logic [2*WORD_W-1:0] rd_data_o,
   input logic                rd_valid_o
);
   logic par_q;
   logic rd_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_q <= 1'b0;
      else        par_q <= ~par_q;
   end

   assign rd_take = rst_n && !par_q && !rd_sel_n_i;

   // R4: first beat two cycles after the read slot
   a_r4_lo_beat: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |=> ##1 rd_valid_o);

   // R4: second beat one cycle later
   a_r4_hi_beat: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |=> ##2 rd_valid_o);

   // R5: valid only follows an accepted read
   a_r5_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> ($past(rd_take, 2) || $past(rd_take, 3)));

   // R6: deselected read slot yields no first beat
   a_r6_rd_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_q && rd_sel_n_i) |=> ##1 !rd_valid_o);

   generate
      if (ZERO_IDLE) begin : g_zero_chk
         // R5: bus is zero while idle
         a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_valid_o |-> (rd_data_o == '0));
      end
   endgenerate
endmodule

bind qb_burst_sram qb_sram_chk #(.WORD_W(WORD_W), .ZERO_IDLE(ZERO_IDLE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_sel_n_i (rd_sel_n_i),
   .rd_data_o  (rd_data_o),
   .rd_valid_o (rd_valid_o)
);

// File: tb/sim_qb_burst_sram.sv
`timescale 1ns/1ps
module sim_qb_burst_sram;
   localparam int W     = 18;
   localparam int AW    = 6;
   localparam int DEPTH = 1 << AW;

   typedef struct {
      int               due;
      logic [2*W-1:0]   data;
      bit               chk;
      string            req;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   addr_i = '0;
   logic            rd_sel_n_i = 1'b1;
   logic            wr_sel_n_i = 1'b1;
   logic [2*W-1:0]  wr_data_i = '0;
   logic [2*W-1:0]  rd_data_o;
   logic            rd_valid_o;

   int   checks = 0;
   int   failures = 0;
   int   cyc = 0;
   bit   done = 0;
   bit   run = 0;
   exp_t q[$];

   logic [4*W-1:0]  mdl [DEPTH];
   bit              known [DEPTH];
   logic [4*W-1:0]  pend = '0;
   bit              pend_v = 0;

   always #2 clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   qb_burst_sram #(.WORD_W(W), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
      .rd_sel_n_i(rd_sel_n_i), .wr_sel_n_i(wr_sel_n_i),
      .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
   );

   function automatic logic [4*W-1:0] pat(input int a, input int s);
      logic [4*W-1:0] v;
      for (int k = 0; k < 4; k++) v[k*W +: W] = W'(a*977 + s*131 + k*29 + 7);
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                        input logic [2*W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
      end
   endtask

   // driver: one even (read) slot followed by one odd (write) slot
   task automatic pair(input bit re, input int ra, input bit we, input int wa,
                       input logic [4*W-1:0] wd, input string rtag,
                       input bit mis_rd = 0, input bit mis_wr = 0);
      exp_t e;
      addr_i     = AW'(ra);
      rd_sel_n_i = !re;
      wr_sel_n_i = !mis_wr;
      wr_data_i  = pend_v ? pend[2*W-1:0] : {(2*W){1'b1}};
      if (re) begin
         e.due = cyc + 2; e.data = mdl[ra][2*W-1:0]; e.chk = known[ra]; e.req = rtag;
         q.push_back(e);
         e.due = cyc + 3; e.data = mdl[ra][4*W-1:2*W];
         q.push_back(e);
      end
      @(negedge clk);
      addr_i     = AW'(wa);
      wr_sel_n_i = !we;
      rd_sel_n_i = !mis_rd;
      wr_data_i  = pend_v ? pend[4*W-1:2*W] : {(2*W){1'b1}};
      if (we) begin
         mdl[wa] = wd;
         known[wa] = 1;
      end
      pend   = wd;
      pend_v = we;
      @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && run) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            check(rd_valid_o === 1'b1, {q[0].req, " valid"}, {{(2*W-1){1'b0}}, rd_valid_o},
                  {{(2*W-1){1'b0}}, 1'b1});
            if (q[0].chk)
               check(rd_data_o === q[0].data, {q[0].req, " data"}, rd_data_o, q[0].data);
            void'(q.pop_front());
         end else begin
            // R5: idle cycles carry no valid and a zero bus
            check(rd_valid_o === 1'b0 && rd_data_o === '0, "R5 idle", rd_data_o, '0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         known[i] = 0;
         mdl[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check(rd_valid_o === 1'b0 && rd_data_o === '0, "R1 reset", rd_data_o, '0);
      rst_n = 1'b1;
      run   = 1;
      // R1: cycle 0 is a read slot (burst appears in cycles 2 and 3)
      pair(1, 5, 1, 3, pat(3, 1), "R1");
      // R7: read right after the write address to the same location
      pair(1, 3, 0, 0, '0, "R7");
      // R8, R3: full-rate interleaving, each read follows the previous write
      for (int a = 0; a < 8; a++)
         pair(1, (a == 0) ? 3 : a + 7, 1, a + 8, pat(a + 8, 1), "R8");
      pair(1, 15, 0, 0, '0, "R8");
      pair(1, 8, 0, 0, '0, "R3");
      // R9: read slot precedes write to same address -> old data, then new
      pair(1, 10, 1, 10, pat(10, 2), "R9");
      pair(1, 10, 0, 0, '0, "R9");
      // R6: deselected read while a write runs, then readback
      pair(0, 10, 1, 20, pat(20, 3), "R6");
      pair(1, 20, 1, 21, pat(21, 3), "R6");
      // R6: deselected write slot leaves location 21 unchanged
      pair(1, 21, 0, 21, pat(21, 9), "R6");
      pair(1, 21, 0, 0, '0, "R6");
      // R2: write select in even slot and read select in odd slot are ignored
      pair(0, 21, 0, 22, '0, "R2", 1, 1);
      pair(1, 21, 0, 0, '0, "R2");
      rd_sel_n_i = 1'b1;
      wr_sel_n_i = 1'b1;
      repeat (6) @(negedge clk);
      check(q.size() == 0, "R4 drained", 2*W'(q.size()), '0);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule